// File: doc/BRIEF.md
# PWM Input Stall Guard

This block watches the four PWM input lines of a two-bridge power stage and spots a line that has stopped switching. A line that stays at one level, high or low, for longer than a set number of clock cycles would leave the supply voltage sitting on the load, so its stall flag is raised and a combined request goes out to put the half-bridge outputs into high impedance. The block never produces a shutdown fault indication. It clears itself as soon as the stalled line switches again.

Each line is synchronized to the free-running system clock and then timed by its own counter, which restarts on every edge. The decoded 3-bit mode picks which lines are guarded: every line in the normal modes, only line 0 in the parallel-bridge mode (code 3'b011), and none in the unguarded mode (code 3'b101). Two active-low pair resets, one for lines 0 and 1 and one for lines 2 and 3, hold the counters and flags of their lines cleared.

Top module: `pwm_stall_guard`

## Requirements
- R1: One cycle after the synchronous reset is sampled high, `stall_o` is 4'b0000 and `hiz_req_o` is 0.
- R2: A guarded line toggling with a period well below `TIMEOUT_CYC` cycles never raises its stall flag.
- R3: A guarded line that stops at either level raises `stall_o[i]` no earlier than `TIMEOUT_CYC` cycles and no later than `TIMEOUT_CYC`+5 cycles after its last change.
- R4: Stall detection is per line: a stopped line raises only its own bit of `stall_o` while the other lines keep switching.
- R5: `hiz_req_o` is high exactly in the cycle after any bit of `stall_o` was high.
- R6: After a stall, the first edge on the line clears its flag within 5 cycles, with no reset needed.
- R7: When `mode_i` is 3'b101, all stall flags are cleared one cycle later and stay clear whatever the lines do.
- R8: When `mode_i` is 3'b011, only line 0 is guarded; `stall_o[3:1]` stay 0.
- R9: While `pair_rst_n_i[0]` is low, `stall_o[1:0]` are 0; while `pair_rst_n_i[1]` is low, `stall_o[3:2]` are 0. Counting starts from zero on release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, free running |
| rst | input | 1 | Synchronous reset, active high |
| pwm_i | input | 4 | PWM input lines, asynchronous to `clk` |
| mode_i | input | 3 | Decoded output-configuration mode |
| pair_rst_n_i | input | 2 | Active-low reset per bridge pair (bit 0: lines 0-1, bit 1: lines 2-3) |
| stall_o | output | 4 | Per-line stall flag, registered |
| hiz_req_o | output | 1 | Request to place outputs in high impedance, registered |

## Verification
The hardest state to reach from the ports is a single line frozen at a chosen level while its neighbours keep switching, sampled just before and just after the timeout boundary. The bench drives each line from a free-running toggler that can be switched off per line and replaced by a held level, forces a fresh edge before each hold so the start of the quiet interval is known to the cycle, and sweeps every line at both levels. Mode and pair-reset masking are reached by holding all lines quiet for several timeouts under each setting.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;
  localparam int unsigned NUM_LINES = 4;

  typedef enum logic [2:0] {
    MODE_BRIDGE_DIFF = 3'b000,
    MODE_PARALLEL    = 3'b011,
    MODE_UNGUARDED   = 3'b101
  } guard_mode_e;

  // Which lines are guarded in a given mode.
  function automatic logic [NUM_LINES-1:0] guard_mask(input logic [2:0] mode);
    logic [NUM_LINES-1:0] m;
    unique case (mode)
      MODE_UNGUARDED: m = '0;
      MODE_PARALLEL:  m = {{(NUM_LINES-1){1'b0}}, 1'b1};
      default:        m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pwm_line_sync.sv
module pwm_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_stall_timer.sv
module pwm_stall_timer #(
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic level,
  output logic stall
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          stall_q;
  logic          edge_seen;

  assign edge_seen = level ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      cnt_q   <= '0;
      stall_q <= 1'b0;
    end else begin
      prev_q <= level;
      if (!enable || edge_seen) begin
        cnt_q   <= '0;
        stall_q <= 1'b0;
      end else if (cnt_q == LAST) begin
        stall_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign stall = stall_q;
endmodule

// File: rtl/pwm_stall_guard.sv
module pwm_stall_guard
  import pwm_guard_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pwm_i,
  input  logic [2:0]           mode_i,
  input  logic [1:0]           pair_rst_n_i,
  output logic [NUM_LINES-1:0] stall_o,
  output logic                 hiz_req_o
);
  logic [NUM_LINES-1:0] mode_mask;
  logic [NUM_LINES-1:0] line_en;
  logic [NUM_LINES-1:0] line_lvl;
  logic [NUM_LINES-1:0] line_stall;
  logic                 hiz_q;

  assign mode_mask = guard_mask(mode_i);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign line_en[i] = mode_mask[i] & pair_rst_n_i[i/2];

    pwm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (pwm_i[i]),
      .dout (line_lvl[i])
    );

    pwm_stall_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .enable (line_en[i]),
      .level  (line_lvl[i]),
      .stall  (line_stall[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) hiz_q <= 1'b0;
    else     hiz_q <= |line_stall;
  end

  assign stall_o   = line_stall;
  assign hiz_req_o = hiz_q;
endmodule

// File: rtl/pwm_stall_guard_chk.sv
module pwm_stall_guard_chk #(
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] pwm_i,
  input logic [2:0] mode_i,
  input logic [1:0] pair_rst_n_i,
  input logic [3:0] stall_o,
  input logic       hiz_req_o
);
  localparam int unsigned QW = $clog2(TIMEOUT_CYC + 2) + 1;
  localparam logic [QW-1:0] QMAX = '1;

  logic [3:0] last_q;

  always_ff @(posedge clk) last_q <= pwm_i;

  for (genvar i = 0; i < 4; i++) begin : g_quiet
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk) begin
      if (rst || (pwm_i[i] != last_q[i])) quiet_q <= '0;
      else if (quiet_q != QMAX)           quiet_q <= quiet_q + 1'b1;
    end

    // R3: a flag only rises after the line was quiet for the full timeout
    a_r3_no_early_stall: assert property (@(posedge clk) disable iff (rst)
      $rose(stall_o[i]) |-> (quiet_q >= QW'(TIMEOUT_CYC)));
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (stall_o == 4'b0000 && !hiz_req_o));

  a_r5_hiz_set: assert property (@(posedge clk) disable iff (rst)
    (stall_o != 4'b0000) |=> hiz_req_o);

  a_r5_hiz_clear: assert property (@(posedge clk) disable iff (rst)
    (stall_o == 4'b0000) |=> !hiz_req_o);

  a_r7_unguarded_mode: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b101) |=> (stall_o == 4'b0000));

  a_r8_parallel_mode: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b011) |=> (stall_o[3:1] == 3'b000));

  a_r9_pair0_hold: assert property (@(posedge clk) disable iff (rst)
    !pair_rst_n_i[0] |=> (stall_o[1:0] == 2'b00));

  a_r9_pair1_hold: assert property (@(posedge clk) disable iff (rst)
    !pair_rst_n_i[1] |=> (stall_o[3:2] == 2'b00));
endmodule

bind pwm_stall_guard pwm_stall_guard_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pwm_i        (pwm_i),
  .mode_i       (mode_i),
  .pair_rst_n_i (pair_rst_n_i),
  .stall_o      (stall_o),
  .hiz_req_o    (hiz_req_o)
);

// File: tb/pwm_stall_guard_bench.sv
module pwm_stall_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pwm = 4'b0000;
  logic [2:0] mode = 3'b000;
  logic [1:0] prst_n = 2'b11;
  logic [3:0] stall;
  logic       hiz;

  logic [3:0] tog_en   = 4'b0000;
  logic [3:0] hold_val = 4'b0000;
  int         tick     = 0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_stall_guard #(.TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u_pwm_stall_guard (
    .clk          (clk),
    .rst          (rst),
    .pwm_i        (pwm),
    .mode_i       (mode),
    .pair_rst_n_i (prst_n),
    .stall_o      (stall),
    .hiz_req_o    (hiz)
  );

  // Line driver: toggling lines flip every 3 cycles, others follow hold_val.
  always @(negedge clk) begin
    tick = tick + 1;
    for (int i = 0; i < 4; i++) begin
      if (tog_en[i]) begin
        if (tick % 3 == 0) pwm[i] = ~pwm[i];
      end else begin
        pwm[i] = hold_val[i];
      end
    end
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic at_pos();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(4);
    at_pos();
    rst = 1'b0;
    cycles(1);
    // R1: reset state
    check("R1 stall", stall, 4'b0000);
    check("R1 hiz", {3'b000, hiz}, 4'b0000);

    // R2: all lines toggling, no stall
    at_pos();
    tog_en = 4'b1111;
    for (int k = 0; k < 8; k++) begin
      cycles(TMO);
      check("R2 toggling", stall, 4'b0000);
    end

    // R3/R4/R5/R6: sweep each line at each level
    for (int ln = 0; ln < 4; ln++) begin
      for (int lv = 0; lv < 2; lv++) begin
        at_pos();
        tog_en[ln]   = 1'b0;
        hold_val[ln] = ~pwm[ln];
        cycles(3);
        at_pos();
        hold_val[ln] = lv[0];
        cycles(1);            // change lands on this negedge
        cycles(TMO - 1);
        check("R3 not before timeout", stall, 4'b0000);
        check("R5 hiz low before timeout", {3'b000, hiz}, 4'b0000);
        cycles(6);
        check("R3/R4 stalled line only", stall, 4'(1 << ln));
        check("R5 hiz raised", {3'b000, hiz}, 4'b0001);
        at_pos();
        tog_en[ln] = 1'b1;
        cycles(10);
        check("R6 recovered", stall, 4'b0000);
        check("R6 hiz released", {3'b000, hiz}, 4'b0000);
      end
    end

    // R7: unguarded mode with all lines quiet
    at_pos();
    mode = 3'b101;
    tog_en = 4'b0000;
    hold_val = 4'b1010;
    cycles(3 * TMO);
    check("R7 unguarded", stall, 4'b0000);
    check("R7 hiz", {3'b000, hiz}, 4'b0000);
    at_pos();
    mode = 3'b000;
    cycles(TMO + 6);
    check("R3 guard restored all lines", stall, 4'b1111);

    // R8: parallel mode
    at_pos();
    mode = 3'b011;
    cycles(3 * TMO);
    check("R8 parallel only line0", stall, 4'b0001);
    check("R8 hiz", {3'b000, hiz}, 4'b0001);

    // R9: pair resets
    at_pos();
    mode = 3'b000;
    prst_n = 2'b10;
    cycles(3 * TMO);
    check("R9 pair0 held", stall, 4'b1100);
    at_pos();
    prst_n = 2'b01;
    cycles(3);
    check("R9 pair1 held", stall[3:2] == 2'b00 ? 4'b0000 : stall, 4'b0000);
    cycles(3 * TMO);
    check("R9 pair1 held, pair0 counts", stall, 4'b0011);
    at_pos();
    prst_n = 2'b00;
    cycles(3);
    check("R9 both pairs held", stall, 4'b0000);
    check("R5 hiz follows clear", {3'b000, hiz}, 4'b0000);
    at_pos();
    prst_n = 2'b11;
    cycles(TMO - 2);
    check("R9 count restarts at release", stall, 4'b0000);
    cycles(8);
    check("R9 stall after release", stall, 4'b1111);

    // R1: reset mid-stall
    at_pos();
    rst = 1'b1;
    cycles(2);
    check("R1 reset mid-stall", stall, 4'b0000);
    check("R1 reset hiz", {3'b000, hiz}, 4'b0000);
    at_pos();
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule